// File: doc/BRIEF.md
# NAND Page-Read Command and Address Sequencer

This block produces the control-side bus cycles that open a page read on a raw NAND flash part. A request gives a block number, a page inside that block, a byte column and a command byte. The block turns the block and page into a row address. It waits for the device to report ready, then emits the command and address cycles one at a time on an 8-bit data bus. Each cycle is marked as either a command or an address cycle. After the last cycle it waits for ready again, and then signals completion.

The address layout is fixed at elaboration time. Large-page layout is for 2 KiB pages and carries a trailing read-confirm command. Small-page layout is for 512-byte pages and has no confirm. A second parameter adds one more row cycle. A third parameter selects a 16-bit device bus. On a 16-bit bus the large-page column is given in words instead of bytes. On large-page parts, a request for the spare-area read is rewritten as a plain read whose column starts just past the page data. Each bus cycle is one write-strobe clock followed by a fixed number of idle clocks. Data transfer and error correction are handled elsewhere.

Top module: `flash_cmd_addr_seq`

## Requirements
- R1: After a request is accepted, no bus cycle is issued while `rdy_i` is low. The first cycle follows the first clock on which `rdy_i` is seen high.
- R2: After the last bus cycle, `done_o` rises only after `rdy_i` has been seen high. `done_o` is high for exactly one clock, and `busy_o` is low from that same clock on.
- R3: The row address equals block × PAGES_PER_BLK + page. Its low byte, then its middle byte (bits 15:8), are sent as address cycles.
- R4: The large-page order is as follows: a command cycle with the request command, column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, and a final command cycle of 0x30.
- R5: With EXTRA_ROW set, one more address cycle follows the row middle byte (before any confirm). It carries row bits 19:16 in data bits 3:0 and zeros above them.
- R6: In large-page layout, request command 0x50 is sent as 0x00, and PAGE_BYTES is added to its column (modulo 2^16). Other commands pass unchanged.
- R7: In large-page layout with BUS16 set, the column is shifted right by one after any R6 adjustment and before it is sent.
- R8: The small-page order is as follows: a command cycle with the unchanged request command, column bits 7:0, row bits 7:0, row bits 15:8, and the optional R5 cycle. No confirm follows.
- R9: Each bus cycle raises `we_o` for exactly one clock. Successive strobes of one sequence are CYC_CLKS clocks apart. `cyc_addr_o` is 0 for a command cycle and 1 for an address cycle, and `data_o` carries the byte.
- R10: A `start_i` pulse that arrives while `busy_o` is high is ignored. The sequence in flight keeps the fields it latched when the request was accepted.
- R11: During and right after reset, `busy_o`, `done_o` and `we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| blk_i | input | BLK_W | Block number |
| page_i | input | PAGE_W | Page within the block |
| col_i | input | 16 | Byte column offset |
| cmd_i | input | 8 | Command byte of the request |
| rdy_i | input | 1 | Device ready (1) / busy (0) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock completion pulse |
| we_o | output | 1 | One-clock write strobe per bus cycle |
| cyc_addr_o | output | 1 | Cycle kind: 0 command, 1 address |
| data_o | output | 8 | Byte driven in the current cycle |

## Verification
The bench builds three instances side by side, each with 20-bit blocks, 4 pages per block and 2-clock cycles. The first is large-page with the extra row cycle on an 8-bit bus. The second is large-page on a 16-bit bus without the extra cycle. The third is small-page with the extra cycle. The 20-bit block field pushes the row past bit 19, so the 4-bit mask on the extra cycle is exercised. A sweep over 16 spread-out block values and every page, with mixed plain and spare-area commands and odd and wrapping columns, covers the rewrite, the word shift and both layouts. Every request also tests the ready waits and an ignored second start.

// File: rtl/fcas_pkg.sv
package fcas_pkg;
  localparam int SEQ_MAX = 7;
  localparam int COL_W   = 16;
  localparam int ROW_OUT = 24;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_SPARE   = 8'h50;
  localparam logic [7:0] OP_CONFIRM = 8'h30;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_SEND, ST_POST} seq_state_e;

  typedef struct packed {
    logic       is_addr;
    logic [7:0] val;
  } bus_cyc_t;
endpackage

// File: rtl/fcas_row.sv
module fcas_row #(
  parameter int BLK_W         = 12,
  parameter int PAGE_W        = 6,
  parameter int PAGES_PER_BLK = 64
) (
  input  logic [BLK_W-1:0]               blk_i,
  input  logic [PAGE_W-1:0]              page_i,
  output logic [fcas_pkg::ROW_OUT-1:0]   row_o
);
  localparam int ROW_W = BLK_W + PAGE_W;

  logic [ROW_W-1:0] row_full;

  always_comb begin
    row_full = ROW_W'(blk_i) * ROW_W'(PAGES_PER_BLK) + ROW_W'(page_i);
    row_o    = fcas_pkg::ROW_OUT'(row_full);
  end
endmodule

// File: rtl/fcas_fmt.sv
module fcas_fmt
  import fcas_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter bit EXTRA_ROW  = 1'b0,
  parameter bit BUS16      = 1'b0,
  parameter int PAGE_BYTES = 2048
) (
  input  logic [COL_W-1:0]           col_i,
  input  logic [7:0]                 cmd_i,
  input  logic [ROW_OUT-1:0]         row_i,
  output bus_cyc_t [SEQ_MAX-1:0]     cyc_o,
  output logic [2:0]                 len_o
);
  logic [3:0] row_top;
  logic       unused_row;

  assign row_top    = row_i[19:16];
  assign unused_row = ^row_i[ROW_OUT-1:20];

  generate
    if (LARGE_PAGE) begin : g_large
      logic [COL_W-1:0] col_w;
      logic [7:0]       op;

      always_comb begin
        col_w = col_i;
        op    = cmd_i;
        if (cmd_i == OP_SPARE) begin
          op    = OP_READ;
          col_w = col_i + COL_W'(PAGE_BYTES);
        end
        if (BUS16) col_w = col_w >> 1;

        cyc_o    = '0;
        cyc_o[0] = '{is_addr: 1'b0, val: op};
        cyc_o[1] = '{is_addr: 1'b1, val: col_w[7:0]};
        cyc_o[2] = '{is_addr: 1'b1, val: col_w[15:8]};
        cyc_o[3] = '{is_addr: 1'b1, val: row_i[7:0]};
        cyc_o[4] = '{is_addr: 1'b1, val: row_i[15:8]};
        if (EXTRA_ROW) begin
          cyc_o[5] = '{is_addr: 1'b1, val: {4'h0, row_top}};
          cyc_o[6] = '{is_addr: 1'b0, val: OP_CONFIRM};
          len_o    = 3'd7;
        end else begin
          cyc_o[5] = '{is_addr: 1'b0, val: OP_CONFIRM};
          len_o    = 3'd6;
        end
      end
    end else begin : g_small
      logic unused_col;
      assign unused_col = ^col_i[COL_W-1:8];

      always_comb begin
        cyc_o    = '0;
        cyc_o[0] = '{is_addr: 1'b0, val: cmd_i};
        cyc_o[1] = '{is_addr: 1'b1, val: col_i[7:0]};
        cyc_o[2] = '{is_addr: 1'b1, val: row_i[7:0]};
        cyc_o[3] = '{is_addr: 1'b1, val: row_i[15:8]};
        if (EXTRA_ROW) begin
          cyc_o[4] = '{is_addr: 1'b1, val: {4'h0, row_top}};
          len_o    = 3'd5;
        end else begin
          len_o    = 3'd4;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fcas_fsm.sv
module fcas_fsm
  import fcas_pkg::*;
#(
  parameter int CYC_CLKS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     rdy_i,
  input  bus_cyc_t [SEQ_MAX-1:0]   cyc_i,
  input  logic [2:0]               len_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     we_o,
  output logic                     kind_o,
  output logic [7:0]               data_o
);
  localparam int TMR_W = (CYC_CLKS < 2) ? 1 : $clog2(CYC_CLKS);

  seq_state_e             state;
  bus_cyc_t [SEQ_MAX-1:0] seq_q;
  logic [2:0]             len_q;
  logic [2:0]             idx;
  logic [TMR_W-1:0]       tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      seq_q  <= '0;
      len_q  <= '0;
      idx    <= '0;
      tmr    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      we_o   <= 1'b0;
      kind_o <= 1'b0;
      data_o <= '0;
    end else begin
      done_o <= 1'b0;
      we_o   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            seq_q  <= cyc_i;
            len_q  <= len_i;
            busy_o <= 1'b1;
            state  <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (rdy_i) begin
            idx   <= '0;
            tmr   <= '0;
            state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (idx == len_q) begin
            state <= ST_POST;
          end else begin
            we_o   <= 1'b1;
            kind_o <= seq_q[idx].is_addr;
            data_o <= seq_q[idx].val;
            idx    <= idx + 1'b1;
            tmr    <= TMR_W'(CYC_CLKS - 1);
          end
        end
        ST_POST: begin
          if (rdy_i) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_addr_seq.sv
module flash_cmd_addr_seq
  import fcas_pkg::*;
#(
  parameter int BLK_W         = 12,
  parameter int PAGE_W        = 6,
  parameter int PAGES_PER_BLK = 64,
  parameter int PAGE_BYTES    = 2048,
  parameter bit LARGE_PAGE    = 1'b1,
  parameter bit EXTRA_ROW     = 1'b0,
  parameter bit BUS16         = 1'b0,
  parameter int CYC_CLKS      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [15:0]       col_i,
  input  logic [7:0]        cmd_i,
  input  logic              rdy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              we_o,
  output logic              cyc_addr_o,
  output logic [7:0]        data_o
);
  logic [ROW_OUT-1:0]     row;
  bus_cyc_t [SEQ_MAX-1:0] cyc;
  logic [2:0]             len;

  fcas_row #(
    .BLK_W(BLK_W), .PAGE_W(PAGE_W), .PAGES_PER_BLK(PAGES_PER_BLK)
  ) u_row (
    .blk_i(blk_i), .page_i(page_i), .row_o(row)
  );

  fcas_fmt #(
    .LARGE_PAGE(LARGE_PAGE), .EXTRA_ROW(EXTRA_ROW),
    .BUS16(BUS16), .PAGE_BYTES(PAGE_BYTES)
  ) u_fmt (
    .col_i(col_i), .cmd_i(cmd_i), .row_i(row), .cyc_o(cyc), .len_o(len)
  );

  fcas_fsm #(.CYC_CLKS(CYC_CLKS)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .rdy_i(rdy_i),
    .cyc_i(cyc), .len_i(len),
    .busy_o(busy_o), .done_o(done_o), .we_o(we_o),
    .kind_o(cyc_addr_o), .data_o(data_o)
  );
endmodule

// File: rtl/fcas_chk.sv
module fcas_chk #(
  parameter int CYC_CLKS = 2
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic rdy_i,
  input logic busy_o,
  input logic done_o,
  input logic we_o
);
  assert_we_in_busy_R1: assert property (@(posedge clk) disable iff (rst)
    we_o |-> busy_o);

  assert_done_after_rdy_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(rdy_i));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));

  generate
    if (CYC_CLKS > 1) begin : g_gap
      assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
        we_o |=> !we_o);
    end
  endgenerate
endmodule

bind flash_cmd_addr_seq fcas_chk #(.CYC_CLKS(CYC_CLKS)) u_fcas_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .rdy_i(rdy_i),
  .busy_o(busy_o), .done_o(done_o), .we_o(we_o)
);

// File: tb/tb_flash_cmd_addr_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_addr_seq;
  localparam int BW  = 20;
  localparam int PW  = 2;
  localparam int PPB = 4;
  localparam int CYC = 2;
  localparam int NI  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          start = 1'b0;
  logic [BW-1:0] blk   = '0;
  logic [PW-1:0] page  = '0;
  logic [15:0]   col   = '0;
  logic [7:0]    cmd   = '0;
  logic          rdy   [NI];
  logic          busy  [NI];
  logic          done  [NI];
  logic          we    [NI];
  logic          ka    [NI];
  logic [7:0]    dat   [NI];

  int checks = 0;
  int fails  = 0;

  genvar gi;
  generate
    for (gi = 0; gi < NI; gi++) begin : g_dut
      flash_cmd_addr_seq #(
        .BLK_W(BW), .PAGE_W(PW), .PAGES_PER_BLK(PPB),
        .PAGE_BYTES((gi != 2) ? 2048 : 512),
        .LARGE_PAGE(gi != 2), .EXTRA_ROW(gi != 1), .BUS16(gi == 1),
        .CYC_CLKS(CYC)
      ) dut (
        .clk(clk), .rst(rst), .start_i(start), .blk_i(blk), .page_i(page),
        .col_i(col), .cmd_i(cmd), .rdy_i(rdy[gi]),
        .busy_o(busy[gi]), .done_o(done[gi]), .we_o(we[gi]),
        .cyc_addr_o(ka[gi]), .data_o(dat[gi])
      );
    end
  endgenerate

  int         exp_n [NI];
  logic [8:0] exp_c [NI][7];
  bit         oob_req;

  task automatic chk(input bit ok, input string req, input int k, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s inst=%0d actual=0x%0h expected=0x%0h", req, k, act, expv);
    end
  endtask

  task automatic build_exp(input logic [BW-1:0] b, input logic [PW-1:0] p,
                           input logic [15:0] c, input logic [7:0] op);
    logic [31:0] row;
    row = 32'(b) * PPB + 32'(p);
    oob_req = (op == 8'h50);
    for (int k = 0; k < 2; k++) begin
      logic [15:0] cc;
      logic [7:0]  o;
      int n;
      cc = c; o = op;
      if (op == 8'h50) begin o = 8'h00; cc = c + 16'd2048; end
      if (k == 1) cc = cc >> 1;
      exp_c[k][0] = {1'b0, o};
      exp_c[k][1] = {1'b1, cc[7:0]};
      exp_c[k][2] = {1'b1, cc[15:8]};
      exp_c[k][3] = {1'b1, row[7:0]};
      exp_c[k][4] = {1'b1, row[15:8]};
      n = 5;
      if (k == 0) begin exp_c[k][5] = {1'b1, 4'h0, row[19:16]}; n = 6; end
      exp_c[k][n] = {1'b0, 8'h30};
      exp_n[k] = n + 1;
    end
    exp_c[2][0] = {1'b0, op};
    exp_c[2][1] = {1'b1, c[7:0]};
    exp_c[2][2] = {1'b1, row[7:0]};
    exp_c[2][3] = {1'b1, row[15:8]};
    exp_c[2][4] = {1'b1, 4'h0, row[19:16]};
    exp_n[2] = 5;
  endtask

  function automatic string tag(input int k, input int i);
    if (k == 2) return (i >= 2) ? "R3" : "R8";
    if (i == 0) return oob_req ? "R6" : "R4";
    if (i <= 2) return (k == 1) ? "R7" : (oob_req ? "R6" : "R4");
    if (i <= 4) return "R3";
    if (i == 5 && k == 0) return "R5";
    return "R4";
  endfunction

  task automatic run_req(input logic [BW-1:0] b, input logic [PW-1:0] p,
                         input logic [15:0] c, input logic [7:0] op);
    int  got [NI];
    int  last [NI];
    int  post [NI];
    bit  want [NI];
    bit  fin [NI];
    int  t;
    bit  all_fin;
    build_exp(b, p, c, op);
    @(negedge clk);
    blk = b; page = p; col = c; cmd = op; start = 1'b1;
    for (int k = 0; k < NI; k++) rdy[k] = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NI; k++) chk(busy[k] == 1'b1, "R1", k, int'(busy[k]), 1);
    // R10: a second request during the sequence, with different fields
    blk = ~b; page = ~p; col = ~c; cmd = 8'h50 ^ op ^ 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      for (int k = 0; k < NI; k++) chk(we[k] == 1'b0, "R1", k, int'(we[k]), 0);
    end
    for (int k = 0; k < NI; k++) begin
      rdy[k] = 1'b1; got[k] = 0; last[k] = 0; post[k] = 0; want[k] = 0; fin[k] = 0;
    end
    t = 0;
    all_fin = 0;
    while (!all_fin && t < 200) begin
      @(negedge clk);
      t++;
      for (int k = 0; k < NI; k++) begin
        if (!fin[k]) begin
          if (want[k]) begin
            chk(done[k] == 1'b1 && busy[k] == 1'b0, "R2", k, {done[k], busy[k]}, 2);
            fin[k] = 1;
          end else if (done[k]) begin
            chk(1'b0, "R2", k, got[k], exp_n[k]);
            fin[k] = 1;
          end else if (we[k]) begin
            if (got[k] < exp_n[k]) begin
              chk({ka[k], dat[k]} == exp_c[k][got[k]], tag(k, got[k]), k,
                  int'({ka[k], dat[k]}), int'(exp_c[k][got[k]]));
              if (got[k] > 0) chk(t - last[k] == CYC, "R9", k, t - last[k], CYC);
              last[k] = t;
              got[k]++;
              if (got[k] == exp_n[k]) begin rdy[k] = 1'b0; post[k] = 3; end
            end else begin
              chk(1'b0, "R9", k, got[k] + 1, exp_n[k]);
            end
          end else if (post[k] > 0) begin
            post[k]--;
            if (post[k] == 0) begin rdy[k] = 1'b1; want[k] = 1; end
          end
        end
      end
      all_fin = fin[0] && fin[1] && fin[2];
    end
    if (!all_fin) chk(1'b0, "R2", 0, t, 0);
    @(negedge clk);
    for (int k = 0; k < NI; k++) chk(done[k] == 1'b0, "R2", k, int'(done[k]), 0);
  endtask

  initial begin
    for (int k = 0; k < NI; k++) rdy[k] = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NI; k++)
      chk(!busy[k] && !done[k] && !we[k], "R11", k, {busy[k], done[k], we[k]}, 0);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NI; k++)
      chk(!busy[k] && !done[k] && !we[k], "R11", k, {busy[k], done[k], we[k]}, 0);
    for (int b = 0; b < 16; b++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] op;
        case ((b + p) % 4)
          0: op = 8'h00;
          1: op = 8'h50;
          2: op = 8'h50;
          default: op = 8'h01;
        endcase
        run_req(BW'(b * 32'h11111), PW'(p), 16'(b * 389 + p * 1237 + 1), op);
      end
    end
    run_req(BW'(20'hFFFFF), PW'(3), 16'hF901, 8'h50);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule